// File: doc/BRIEF.md
# Two-Level Page Walker with Large-Page Support

This block turns a 32-bit linear address into a physical address. It reads a page directory and, when needed, a page table from memory through one 32-bit read/write port. Each directory entry either points to a 4 KB page table or, when large pages are switched on, maps a whole 4 MB region itself. The walker sets the accessed bit in the final (leaf) entry, and the dirty bit as well on a write. It does this with a read-modify-write that touches memory only when a bit is still missing.

A caller presents a request (linear address, write flag, user flag) while `busy` is low. It later receives a one-cycle response with the physical address, the combined user/read-write permission bits, a simple denial flag, and a not-present fault indication. A single-entry cache holds the last successful translation. Repeated accesses to the same linear page finish without any memory traffic. A write to a page whose dirty bit has not yet been recorded rereads the leaf at its cached address and writes it back. A small control register holds the large-page enable. Writing it keeps only bit 4 and also empties the cache.

Top module: `page_walker`

## Requirements
- R1: The directory entry is read at address {dir_base[31:12], lin[31:22], 2'b00}. If that entry has bit 0 clear, the response has rsp_fault=1 and no memory write takes place.
- R2: For a 4 KB page, the table entry is read at {dirent[31:12], lin[21:12], 2'b00}, and rsp_paddr = {tblent[31:12], lin[11:0]}. If the table entry has bit 0 clear, the response has rsp_fault=1 and no memory write takes place.
- R3: A present directory entry with bit 7 set while control bit 4 is set is a large page. In that case rsp_paddr = {dirent[31:22], lin[21:0]}, and no table entry is read.
- R4: When control bit 4 is clear, directory bit 7 is ignored and the entry is used as a table pointer.
- R5: rsp_acc[1] is the user bit (entry bit 2) and rsp_acc[0] is the read/write bit (entry bit 1). A large page takes them from the directory entry alone. A 4 KB page takes the AND of the directory entry and table entry bits.
- R6: When the leaf entry lacks bit 5, or the access is a write and the leaf lacks bit 6, the leaf is written back with bit 5 set and bit 6 set on writes. A large page's leaf is its directory entry at that entry's own address.
- R7: A control write stores only bit 4 of ctl_wdata; ctl_rdata shows all other bits as zero. The reset value is 0.
- R8: A request whose lin[31:12] matches the cached page completes with rsp_hit=1 and no memory transaction. The one exception is a write hit whose dirty bit is not yet recorded: it rereads the leaf at the cached address and writes it back with bits 5 and 6 set (two transactions).
- R9: Any control write empties the cache, so the next request walks memory (rsp_hit=0).
- R10: At most one memory transaction is outstanding. mem_valid, mem_addr and mem_we stay stable until mem_ready.
- R11: busy is high from request acceptance until the response. Requests offered while busy are ignored. rsp_valid is a single-cycle pulse after which busy is low.
- R12: rsp_deny = user & (~rsp_acc[1] | (write & ~rsp_acc[0])), and it is 0 on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| busy | output | 1 | Walker occupied; requests ignored |
| dir_base | input | 32 | Page directory base (bits 31:12 used) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register contents |
| mem_valid | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_acc | output | 2 | Combined permission bits {user, read/write} |
| rsp_fault | output | 1 | Not-present fault |
| rsp_hit | output | 1 | Served from the cached entry |
| rsp_deny | output | 1 | Permission denial for this access |

## Verification
A vector table drives reads and writes through 4 KB pages, large pages, an absent directory entry and an absent table entry. These separate the two leaf formats and the two fault points, and the user-level cases separate the AND-combined permissions from the directory-only ones. The same directory entry is then walked with large pages disabled and enabled. This shows that bit 7 is honoured only under the control bit, and the count of memory transactions shows whether the table read was skipped. Directed sequences follow a leaf entry through a read (accessed only), a write hit (reread and dirty write-back) and a further write hit (no traffic). Other directed tests check that a control write forces a new walk and that a request offered mid-walk is dropped.

// File: rtl/page_walker.sv
module page_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic        req_user,
  output logic        busy,
  input  logic [31:0] dir_base,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_acc,
  output logic        rsp_fault,
  output logic        rsp_hit,
  output logic        rsp_deny
);
  localparam int BIT_P   = 0;
  localparam int BIT_A   = 5;
  localparam int BIT_D   = 6;
  localparam int BIT_BIG = 7;
  localparam int BIT_EN  = 4;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_RLEAF, S_WLEAF, S_DONE} st_t;
  st_t st;

  logic [31:0] lin_q, leaf_q, leaf_addr_q;
  logic [19:0] base_q, pde_hi_q, ppf_q;
  logic [1:0]  pde_acc_q, acc_q;
  logic        wr_q, usr_q, fault_q, hit_q, big_en_q;

  logic        c_vld, c_dirty;
  logic [19:0] c_lpf, c_ppf;
  logic [31:0] c_leaf;
  logic [1:0]  c_acc;

  wire unused_bits = ^{ctl_wdata[31:BIT_EN+1], ctl_wdata[BIT_EN-1:0], dir_base[11:0]};

  wire [31:0] pde_addr = {base_q, lin_q[31:22], 2'b00};
  wire [31:0] pte_addr = {pde_hi_q, lin_q[21:12], 2'b00};
  wire        xfer     = mem_valid && mem_ready;
  wire        present  = mem_rdata[BIT_P];
  wire        is_big   = mem_rdata[BIT_BIG] && big_en_q;
  wire        c_hit    = c_vld && (c_lpf == req_lin[31:12]);
  wire        need_upd = !mem_rdata[BIT_A] || (wr_q && !mem_rdata[BIT_D]);
  wire        leaf_now = xfer && present && ((st == S_DIR && is_big) || st == S_TBL);
  wire [19:0] new_ppf  = (st == S_DIR) ? {mem_rdata[31:22], lin_q[21:12]} : mem_rdata[31:12];
  wire [1:0]  new_acc  = (st == S_DIR) ? mem_rdata[2:1] : (pde_acc_q & mem_rdata[2:1]);

  assign busy      = (st != S_IDLE);
  assign ctl_rdata = {{(31-BIT_EN){1'b0}}, big_en_q, {BIT_EN{1'b0}}};
  assign mem_valid = (st == S_DIR) || (st == S_TBL) || (st == S_RLEAF) || (st == S_WLEAF);
  assign mem_we    = (st == S_WLEAF);
  assign mem_wdata = leaf_q | (32'd1 << BIT_A) | ({31'd0, wr_q} << BIT_D);
  assign rsp_valid = (st == S_DONE);
  assign rsp_paddr = {ppf_q, lin_q[11:0]};
  assign rsp_acc   = acc_q;
  assign rsp_fault = fault_q;
  assign rsp_hit   = hit_q;
  assign rsp_deny  = !fault_q && usr_q && (!acc_q[1] || (wr_q && !acc_q[0]));

  always_comb begin
    case (st)
      S_DIR:   mem_addr = pde_addr;
      S_TBL:   mem_addr = pte_addr;
      default: mem_addr = leaf_addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      lin_q       <= '0;
      leaf_q      <= '0;
      leaf_addr_q <= '0;
      base_q      <= '0;
      pde_hi_q    <= '0;
      pde_acc_q   <= '0;
      ppf_q       <= '0;
      acc_q       <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      fault_q     <= 1'b0;
      hit_q       <= 1'b0;
      big_en_q    <= 1'b0;
      c_vld       <= 1'b0;
      c_dirty     <= 1'b0;
      c_lpf       <= '0;
      c_ppf       <= '0;
      c_leaf      <= '0;
      c_acc       <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q   <= req_lin;
          wr_q    <= req_write;
          usr_q   <= req_user;
          base_q  <= dir_base[31:12];
          fault_q <= 1'b0;
          hit_q   <= c_hit;
          if (c_hit) begin
            ppf_q       <= c_ppf;
            acc_q       <= c_acc;
            leaf_addr_q <= c_leaf;
            st          <= (req_write && !c_dirty) ? S_RLEAF : S_DONE;
          end else begin
            st <= S_DIR;
          end
        end
        S_DIR: if (xfer) begin
          pde_hi_q  <= mem_rdata[31:12];
          pde_acc_q <= mem_rdata[2:1];
          if (!present) begin
            fault_q <= 1'b1;
            st      <= S_DONE;
          end else if (!is_big) begin
            st <= S_TBL;
          end
        end
        S_TBL: if (xfer && !present) begin
          fault_q <= 1'b1;
          st      <= S_DONE;
        end
        S_RLEAF: if (xfer) begin
          leaf_q <= mem_rdata;
          st     <= S_WLEAF;
        end
        S_WLEAF: if (xfer) begin
          if (wr_q) c_dirty <= 1'b1;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase

      if (leaf_now) begin
        leaf_q      <= mem_rdata;
        leaf_addr_q <= mem_addr;
        ppf_q       <= new_ppf;
        acc_q       <= new_acc;
        c_vld       <= 1'b1;
        c_lpf       <= lin_q[31:12];
        c_ppf       <= new_ppf;
        c_leaf      <= mem_addr;
        c_acc       <= new_acc;
        c_dirty     <= wr_q || mem_rdata[BIT_D];
        st          <= need_upd ? S_WLEAF : S_DONE;
      end

      if (ctl_wr) begin
        big_en_q <= ctl_wdata[BIT_EN];
        c_vld    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_valid,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] ctl_rdata,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic        rsp_hit,
  input logic        rsp_deny
);
  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R10

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[5] && mem_wdata[0]); // R6

  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & ~32'h10) == 32'd0); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !rsp_valid); // R11

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy); // R11

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_deny && !rsp_hit); // R12
endmodule

bind page_walker page_walker_chk u_chk (.*);

// File: tb/test_page_walker.sv
module test_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        busy;
  logic [31:0] dir_base = 32'h0001_0000;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_acc;
  logic        rsp_fault, rsp_hit, rsp_deny;

  page_walker i_page_walker (.*);

  always #10 clk = ~clk;

  logic [31:0] mem  [logic [31:0]];
  bit          seen [logic [31:0]];
  int lat = 0, cnt = 0, n_txn = 0, n_wr = 0, viol = 0;
  int total = 0, bad = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [31:0] r_paddr;
  logic [1:0]  r_acc;
  logic        r_fault, r_hit, r_deny;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst_n && prev_wait && (!mem_valid || mem_addr != prev_addr)) viol++;
    prev_wait <= mem_valid && !mem_ready;
    prev_addr <= mem_addr;
    if (!rst_n) begin
      mem_ready <= 1'b0;
      cnt = 0;
    end else if (mem_valid && mem_ready) begin
      mem_ready <= 1'b0;
      cnt = 0;
      n_txn++;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        n_wr++;
      end else seen[mem_addr] = 1'b1;
    end else if (mem_valid) begin
      if (cnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= rd(mem_addr);
      end else cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    mem.delete();
    seen.delete();
    mem[32'h0001_0000] = 32'h0002_0007;
    mem[32'h0001_0004] = 32'h0C00_0087;
    mem[32'h0001_0008] = 32'h0000_0000;
    mem[32'h0002_0014] = 32'h0030_0007;
    mem[32'h0002_0018] = 32'h0040_0006;
    mem[32'h0002_001C] = 32'h0050_0003;
    mem[32'h0C00_0048] = 32'h0077_7005;
  endtask

  task automatic ctl_write(input logic [31:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic do_req(input logic [31:0] lin, input logic wr, input logic usr);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_lin = lin;
    req_write = wr;
    req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_paddr = rsp_paddr;
    r_acc = rsp_acc;
    r_fault = rsp_fault;
    r_hit = rsp_hit;
    r_deny = rsp_deny;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // {lin, write, user, paddr, fault, acc, deny}
  localparam logic [69:0] VEC [8] = '{
    {32'h0000_5ABC, 1'b0, 1'b0, 32'h0030_0ABC, 1'b0, 2'b11, 1'b0}, // R2 R5
    {32'h0041_2345, 1'b1, 1'b0, 32'h0C01_2345, 1'b0, 2'b11, 1'b0}, // R3
    {32'h0000_6000, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 2'b00, 1'b0}, // R2 fault
    {32'h0080_0010, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 2'b00, 1'b0}, // R1 fault
    {32'h0000_7FFF, 1'b1, 1'b1, 32'h0050_0FFF, 1'b0, 2'b01, 1'b1}, // R5 R12
    {32'h007F_F001, 1'b0, 1'b1, 32'h0C3F_F001, 1'b0, 2'b11, 1'b0}, // R3
    {32'h0000_5000, 1'b1, 1'b1, 32'h0030_0000, 1'b0, 2'b11, 1'b0}, // R2 R12
    {32'h0040_0000, 1'b0, 1'b1, 32'h0C00_0000, 1'b0, 2'b11, 1'b0}  // R3
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int t0, w0;
    repeat (3) @(negedge clk);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 reset mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R7 reset ctl", ctl_rdata, 32'd0);
    rst_n = 1'b1;

    ctl_write(32'hFFFF_FFFF);
    chk("R7 ctl mask", ctl_rdata, 32'h0000_0010);
    ctl_write(32'hFFFF_FFEF);
    chk("R7 ctl clear", ctl_rdata, 32'h0);
    ctl_write(32'h0000_0010);

    init_mem();
    for (int i = 0; i < 8; i++) begin
      lat = i % 3;
      do_req(VEC[i][69:38], VEC[i][37], VEC[i][36]);
      chk("R1 R2 table fault", {31'd0, r_fault}, {31'd0, VEC[i][3]});
      chk("R12 table deny", {31'd0, r_deny}, {31'd0, VEC[i][0]});
      if (!VEC[i][3]) begin
        chk("R2 R3 table paddr", r_paddr, VEC[i][35:4]);
        chk("R5 table acc", {30'd0, r_acc}, {30'd0, VEC[i][2:1]});
      end
    end

    // R1: absent directory entry
    ctl_write(32'h10);
    init_mem();
    lat = 1;
    w0 = n_wr;
    do_req(32'h0080_0010, 1'b1, 1'b0);
    chk("R1 fault", {31'd0, r_fault}, 32'd1);
    chk("R1 no write", n_wr - w0, 32'd0);
    chk("R1 dir addr", {31'd0, seen.exists(32'h0001_0008)}, 32'd1);

    // R2: absent table entry
    w0 = n_wr;
    do_req(32'h0000_6000, 1'b1, 1'b0);
    chk("R2 fault", {31'd0, r_fault}, 32'd1);
    chk("R2 no write", n_wr - w0, 32'd0);

    // R4: big bit ignored without enable
    ctl_write(32'h0);
    init_mem();
    do_req(32'h0041_2345, 1'b0, 1'b0);
    chk("R4 paddr", r_paddr, 32'h0077_7345);
    chk("R4 table read", {31'd0, seen.exists(32'h0C00_0048)}, 32'd1);
    chk("R5 and acc", {30'd0, r_acc}, 32'd2);
    chk("R6 read sets A only", rd(32'h0C00_0048), 32'h0077_7025);

    // R3 + R6: large page write, leaf is the directory entry
    ctl_write(32'h10);
    init_mem();
    t0 = n_txn;
    do_req(32'h0041_2345, 1'b1, 1'b0);
    chk("R3 paddr", r_paddr, 32'h0C01_2345);
    chk("R3 no table read", n_txn - t0, 32'd2);
    chk("R6 big leaf wb", rd(32'h0001_0004), 32'h0C00_00E7);

    // R8: hit with no memory traffic
    t0 = n_txn;
    do_req(32'h0041_2FFF, 1'b0, 1'b1);
    chk("R8 hit", {31'd0, r_hit}, 32'd1);
    chk("R8 no traffic", n_txn - t0, 32'd0);
    chk("R8 hit paddr", r_paddr, 32'h0C01_2FFF);

    // R6/R8: read then write hit on a 4 KB page
    do_req(32'h0000_5ABC, 1'b0, 1'b0);
    chk("R8 miss", {31'd0, r_hit}, 32'd0);
    chk("R6 A set", rd(32'h0002_0014), 32'h0030_0027);
    t0 = n_txn;
    do_req(32'h0000_5004, 1'b1, 1'b0);
    chk("R8 write hit", {31'd0, r_hit}, 32'd1);
    chk("R8 rmw count", n_txn - t0, 32'd2);
    chk("R8 D set", rd(32'h0002_0014), 32'h0030_0067);
    t0 = n_txn;
    do_req(32'h0000_5008, 1'b1, 1'b0);
    chk("R8 dirty recorded", n_txn - t0, 32'd0);

    // R9: control write flushes
    ctl_write(32'h10);
    do_req(32'h0000_5008, 1'b0, 1'b0);
    chk("R9 flushed", {31'd0, r_hit}, 32'd0);
    chk("R9 paddr", r_paddr, 32'h0030_0008);

    // R11: request while busy is dropped
    lat = 2;
    @(negedge clk);
    req_valid = 1'b1;
    req_lin = 32'h0041_2345;
    req_write = 1'b0;
    req_user = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy", {31'd0, busy}, 32'd1);
    req_valid = 1'b1;
    req_lin = 32'h0080_0010;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk("R11 first kept", rsp_paddr, 32'h0C01_2345);
    chk("R11 no fault", {31'd0, rsp_fault}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 idle after", {31'd0, busy}, 32'd0);

    chk("R10 stable request", viol, 32'd0);
    summary();
  end
endmodule